// File: doc/BRIEF.md
# Multithreaded Retirement Thread Selector

This block chooses, in every cycle, which hardware thread may retire the instruction at the head of its reorder-buffer partition. Each thread presents a three-bit status code, a flag saying its head instruction is ready, a flag saying its partition is empty, and the sequence number of its head instruction. A policy input picks between rotating-priority arbitration and age-based arbitration. The answer is a valid flag plus a thread index, and it is formed combinationally from the present inputs and the stored priority order.

In rotating mode the selector keeps an ordered list of thread indices. The first thread in the list that may retire wins. When the retire logic uses that choice it raises an accept input, and on that clock edge the winner moves to the back of the list. In age-based mode the ready thread whose head instruction carries the smallest sequence number wins. A retire loop that asks for several picks within one cycle gets a stable answer until it accepts one of them. A build with a single thread has no arbiter: it reports thread 0 whenever that thread's status allows retirement.

Top module: `commit_thread_sel`

## Requirements
- R1: Status codes 0 (running), 1 (idle) and 4 (fetch-trap pending) let a thread take part. Codes 2 (squashing) and 3 (trap pending), and the unused codes 5 to 7, keep it out under every policy.
- R2: The policy input uses 0 for rotating priority and 1 for oldest-ready. Value 2 (aggressive) and value 3 both give exactly the oldest-ready result.
- R3: After reset the priority list holds the thread indices in ascending order, so the first rotating grant goes to the lowest-numbered thread that qualifies.
- R4: In rotating mode the grant goes to the first thread in list order whose status allows retirement and whose head-ready flag is 1. The empty flag is not consulted.
- R5: In rotating mode, when accept is 1 while the valid output is 1, the granted thread moves to the back of the list at the next clock edge, and the other threads keep their relative order. When accept is 0 the list does not change.
- R6: In the oldest-ready and aggressive modes, accept leaves the priority list unchanged.
- R7: In oldest-ready mode a thread qualifies when its status allows retirement, its head is ready and its partition is not empty. Among qualifying threads the smallest head sequence number wins, and equal numbers go to the lower thread index.
- R8: When no thread qualifies, the valid output is 0 and the index output is 0.
- R9: Outputs follow the inputs within the same cycle. Repeated samples in one cycle with accept at 0 give the same answer.
- R10: With one thread configured, the valid output equals "status allows retirement" for thread 0, regardless of the ready and empty flags, and the index is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_i | input | 2 | Arbitration policy code |
| status_i | input | NUM_THREADS*3 | Per-thread status codes, thread t in bits [3t+2:3t] |
| head_rdy_i | input | NUM_THREADS | Per-thread head-ready flag |
| rob_empty_i | input | NUM_THREADS | Per-thread partition-empty flag |
| head_seq_i | input | NUM_THREADS*SEQ_W | Per-thread head sequence number, thread t in bits [SEQ_W*t +: SEQ_W] |
| accept_i | input | 1 | Current choice was used this cycle |
| sel_valid_o | output | 1 | A thread is selected |
| sel_tid_o | output | TID_W | Selected thread index |

## Verification
The assertions assume that accept only matters in a cycle where the selector reports a valid choice, and that the status, ready and sequence inputs stay steady between clock edges. The stimulus changes inputs only just after a rising edge and samples at the falling edge. It draws status codes from the full three-bit range, so every ineligible code appears. Sequence numbers come from a narrow range so that age ties happen often. Accept is also raised in cycles with no valid choice and under the age-based policies, so the model shows whether the list moves when it should not.

// File: rtl/commit_sel_pkg.sv
package commit_sel_pkg;

   localparam int STAT_W = 3;

   typedef enum logic [STAT_W-1:0] {
      ST_RUNNING     = 3'd0,
      ST_IDLE        = 3'd1,
      ST_SQUASHING   = 3'd2,
      ST_TRAP_WAIT   = 3'd3,
      ST_FETCH_TRAP  = 3'd4
   } thr_status_e;

   typedef enum logic [1:0] {
      POL_ROTATE     = 2'd0,
      POL_OLDEST     = 2'd1,
      POL_AGGRESSIVE = 2'd2,
      POL_SPARE      = 2'd3
   } sel_policy_e;

   function automatic logic status_allows(input logic [STAT_W-1:0] code);
      return (code == ST_RUNNING) || (code == ST_IDLE) || (code == ST_FETCH_TRAP);
   endfunction

endpackage

// File: rtl/commit_sel_elig.sv
module commit_sel_elig
   import commit_sel_pkg::*;
#(
   parameter int NUM_THREADS = 4
)(
   input  logic [NUM_THREADS*STAT_W-1:0] status_i,
   input  logic [NUM_THREADS-1:0]        head_rdy_i,
   input  logic [NUM_THREADS-1:0]        rob_empty_i,
   output logic [NUM_THREADS-1:0]        elig_o,
   output logic [NUM_THREADS-1:0]        rot_cand_o,
   output logic [NUM_THREADS-1:0]        age_cand_o
);

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      logic [STAT_W-1:0] code;
      assign code          = status_i[t*STAT_W +: STAT_W];
      assign elig_o[t]     = status_allows(code);
      assign rot_cand_o[t] = elig_o[t] & head_rdy_i[t];
      assign age_cand_o[t] = elig_o[t] & head_rdy_i[t] & ~rob_empty_i[t];
   end

endmodule

// File: rtl/commit_sel_rotate.sv
module commit_sel_rotate #(
   parameter int NUM_THREADS = 4,
   localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_THREADS-1:0] cand_i,
   input  logic                   upd_en_i,
   output logic                   valid_o,
   output logic [TID_W-1:0]       tid_o
);

   logic [TID_W-1:0] order_q [NUM_THREADS];
   logic [TID_W-1:0] order_d [NUM_THREADS];
   int unsigned      win_pos;

   // first candidate in list order
   always_comb begin
      valid_o = 1'b0;
      tid_o   = '0;
      win_pos = 0;
      for (int i = 0; i < NUM_THREADS; i++) begin
         if (!valid_o && cand_i[order_q[i]]) begin
            valid_o = 1'b1;
            tid_o   = order_q[i];
            win_pos = i;
         end
      end
   end

   // winner leaves its slot, entries behind it close the gap, winner at tail
   always_comb begin
      for (int i = 0; i < NUM_THREADS; i++) begin
         if (i < int'(win_pos) || i == NUM_THREADS - 1) order_d[i] = order_q[i];
         else                                          order_d[i] = order_q[i+1];
      end
      order_d[NUM_THREADS-1] = tid_o;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_THREADS; i++) order_q[i] <= TID_W'(i);
      end else if (upd_en_i && valid_o) begin
         for (int i = 0; i < NUM_THREADS; i++) order_q[i] <= order_d[i];
      end
   end

   // every thread index appears in the list exactly once
   logic [NUM_THREADS-1:0] seen;
   always_comb begin
      seen = '0;
      for (int i = 0; i < NUM_THREADS; i++)
         if (int'(order_q[i]) < NUM_THREADS) seen[order_q[i]] = 1'b1;
   end

   a_r5_list_is_perm: assert property (@(posedge clk) disable iff (!rst_n)
      seen == {NUM_THREADS{1'b1}});

   a_r5_hold_without_accept: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en_i |=> $stable(order_q[0]) && $stable(order_q[NUM_THREADS-1]));

   a_r5_winner_to_tail: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en_i && valid_o) |=> order_q[NUM_THREADS-1] == $past(tid_o));

endmodule

// File: rtl/commit_sel_oldest.sv
module commit_sel_oldest #(
   parameter int NUM_THREADS = 4,
   parameter int SEQ_W = 16,
   localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_THREADS-1:0]       cand_i,
   input  logic [NUM_THREADS*SEQ_W-1:0] seq_i,
   output logic                         valid_o,
   output logic [TID_W-1:0]             tid_o
);

   logic [SEQ_W-1:0] best_seq;

   // strict less-than keeps the lower index on equal ages
   always_comb begin
      valid_o  = 1'b0;
      tid_o    = '0;
      best_seq = '0;
      for (int t = 0; t < NUM_THREADS; t++) begin
         if (cand_i[t] && (!valid_o || seq_i[t*SEQ_W +: SEQ_W] < best_seq)) begin
            valid_o  = 1'b1;
            tid_o    = TID_W'(t);
            best_seq = seq_i[t*SEQ_W +: SEQ_W];
         end
      end
   end

   // no qualifying thread beats the winner
   logic beaten;
   always_comb begin
      beaten = 1'b0;
      for (int t = 0; t < NUM_THREADS; t++) begin
         if (valid_o && cand_i[t]) begin
            if (seq_i[t*SEQ_W +: SEQ_W] < seq_i[int'(tid_o)*SEQ_W +: SEQ_W]) beaten = 1'b1;
            if (seq_i[t*SEQ_W +: SEQ_W] == seq_i[int'(tid_o)*SEQ_W +: SEQ_W] && t < int'(tid_o))
               beaten = 1'b1;
         end
      end
   end

   a_r7_oldest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> !beaten);

   a_r7_winner_qualifies: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> cand_i[tid_o]);

endmodule

// File: rtl/commit_thread_sel.sv
module commit_thread_sel
   import commit_sel_pkg::*;
#(
   parameter int NUM_THREADS = 4,
   parameter int SEQ_W = 16,
   localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [1:0]                   policy_i,
   input  logic [NUM_THREADS*3-1:0]     status_i,
   input  logic [NUM_THREADS-1:0]       head_rdy_i,
   input  logic [NUM_THREADS-1:0]       rob_empty_i,
   input  logic [NUM_THREADS*SEQ_W-1:0] head_seq_i,
   input  logic                         accept_i,
   output logic                         sel_valid_o,
   output logic [TID_W-1:0]             sel_tid_o
);

   initial begin
      a_prm_threads: assert (NUM_THREADS >= 1 && NUM_THREADS <= 64);
      a_prm_seq:     assert (SEQ_W >= 1 && SEQ_W <= 64);
   end

   logic [NUM_THREADS-1:0] elig, rot_cand, age_cand;
   logic                   rot_mode;

   assign rot_mode = (policy_i == POL_ROTATE);

   commit_sel_elig #(.NUM_THREADS(NUM_THREADS)) i_elig (
      .status_i    (status_i),
      .head_rdy_i  (head_rdy_i),
      .rob_empty_i (rob_empty_i),
      .elig_o      (elig),
      .rot_cand_o  (rot_cand),
      .age_cand_o  (age_cand)
   );

   if (NUM_THREADS == 1) begin : g_solo
      assign sel_valid_o = elig[0];
      assign sel_tid_o   = '0;
   end else begin : g_multi
      logic             rot_valid, age_valid, rot_upd;
      logic [TID_W-1:0] rot_tid, age_tid;

      assign rot_upd = rot_mode & accept_i;

      commit_sel_rotate #(.NUM_THREADS(NUM_THREADS)) i_rotate (
         .clk      (clk),
         .rst_n    (rst_n),
         .cand_i   (rot_cand),
         .upd_en_i (rot_upd),
         .valid_o  (rot_valid),
         .tid_o    (rot_tid)
      );

      commit_sel_oldest #(.NUM_THREADS(NUM_THREADS), .SEQ_W(SEQ_W)) i_oldest (
         .clk     (clk),
         .rst_n   (rst_n),
         .cand_i  (age_cand),
         .seq_i   (head_seq_i),
         .valid_o (age_valid),
         .tid_o   (age_tid)
      );

      assign sel_valid_o = rot_mode ? rot_valid : age_valid;
      assign sel_tid_o   = rot_mode ? rot_tid   : age_tid;

      a_r6_no_rotate_in_age_mode: assert property (@(posedge clk) disable iff (!rst_n)
         !rot_mode |-> !rot_upd);

      a_r4_rotate_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
         (rot_mode && sel_valid_o) |-> head_rdy_i[sel_tid_o]);

      a_r7_age_needs_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
         (!rot_mode && sel_valid_o) |-> !rob_empty_i[sel_tid_o] && head_rdy_i[sel_tid_o]);
   end

   a_r1_winner_status_ok: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid_o |-> (status_i[int'(sel_tid_o)*3 +: 3] inside {3'd0, 3'd1, 3'd4}));

   a_r8_idle_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_valid_o |-> sel_tid_o == '0);

   a_r8_none_when_all_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (elig == '0) |-> !sel_valid_o);

endmodule

// File: tb/test_commit_thread_sel.sv
module test_commit_thread_sel;
   localparam int CLK_PERIOD = 10;
   localparam int NT = 4;
   localparam int SW = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [1:0]      policy = 2'd0;
   logic [NT*3-1:0] status = '0;
   logic [NT-1:0]   rdy = '0;
   logic [NT-1:0]   emp = '1;
   logic [NT*SW-1:0] seq = '0;
   logic            acc = 1'b0;
   logic            sel_valid;
   logic [1:0]      sel_tid;

   logic [2:0]      st1 = 3'd2;
   logic            rdy1 = 1'b0, emp1 = 1'b1, v1;
   logic [SW-1:0]   seq1 = '0;
   logic [0:0]      tid1;

   int total = 0, bad = 0;
   bit finished = 0;
   int rr_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   commit_thread_sel #(.NUM_THREADS(NT), .SEQ_W(SW)) i_commit_thread_sel (
      .clk(clk), .rst_n(rst_n), .policy_i(policy), .status_i(status),
      .head_rdy_i(rdy), .rob_empty_i(emp), .head_seq_i(seq), .accept_i(acc),
      .sel_valid_o(sel_valid), .sel_tid_o(sel_tid));

   commit_thread_sel #(.NUM_THREADS(1), .SEQ_W(SW)) i_commit_thread_sel_solo (
      .clk(clk), .rst_n(rst_n), .policy_i(policy), .status_i(st1),
      .head_rdy_i(rdy1), .rob_empty_i(emp1), .head_seq_i(seq1), .accept_i(1'b0),
      .sel_valid_o(v1), .sel_tid_o(tid1));

   function automatic bit ok_status(input logic [2:0] c);
      return c == 3'd0 || c == 3'd1 || c == 3'd4;
   endfunction

   function automatic logic [2:0] st_of(input int t);
      return status[t*3 +: 3];
   endfunction

   function automatic logic [SW-1:0] seq_of(input int t);
      return seq[t*SW +: SW];
   endfunction

   task automatic check(input string req, input bit av, input int at, input bit ev, input int et);
      total++;
      if (av !== ev || at != et) begin
         bad++;
         $display("FAIL %s: got valid=%0d tid=%0d expected valid=%0d tid=%0d", req, av, at, ev, et);
      end
   endtask

   // behavioural reference for the current cycle
   task automatic model(output bit ev, output int et);
      ev = 0; et = 0;
      if (policy == 2'd0) begin
         foreach (rr_q[k]) if (!ev && ok_status(st_of(rr_q[k])) && rdy[rr_q[k]]) begin
            ev = 1; et = rr_q[k];
         end
      end else begin
         for (int t = 0; t < NT; t++)
            if (ok_status(st_of(t)) && rdy[t] && !emp[t])
               if (!ev || seq_of(t) < seq_of(et)) begin ev = 1; et = t; end
      end
   endtask

   // sample at falling edge, compare, advance model, then move past rising edge
   task automatic step(input string req);
      bit ev; int et;
      @(negedge clk);
      model(ev, et);
      check(ev ? req : "R8", sel_valid, int'(sel_tid), ev, et);
      if (policy == 2'd0 && acc && ev) begin
         int idx = -1;
         foreach (rr_q[k]) if (rr_q[k] == et) idx = k;
         rr_q.delete(idx);
         rr_q.push_back(et);
      end
      @(posedge clk); #1;
   endtask

   task automatic set_all(input logic [2:0] s0, s1, s2, s3);
      status = {s3, s2, s1, s0};
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog: got no finish expected finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      bit ev; int et;
      rr_q = {0, 1, 2, 3};
      repeat (3) @(posedge clk);
      #1;
      // reset state: nothing qualifies
      @(negedge clk);
      check("R8", sel_valid, int'(sel_tid), 0, 0);
      rst_n = 1'b1;
      @(posedge clk); #1;

      // R3: ascending order after reset
      policy = 2'd0; set_all(3'd0, 3'd0, 3'd0, 3'd0); rdy = 4'b1110; emp = '0;
      @(negedge clk); check("R3", sel_valid, int'(sel_tid), 1, 1);
      @(posedge clk); #1;

      // R1: each status code on thread 2 alone
      for (int c = 0; c < 8; c++) begin
         set_all(3'd2, 3'd3, 3'(c), 3'd3); rdy = '1;
         @(negedge clk);
         check("R1", sel_valid, int'(sel_tid), ok_status(3'(c)), ok_status(3'(c)) ? 2 : 0);
         @(posedge clk); #1;
      end

      // R4: empty flag ignored in rotating mode
      set_all(3'd1, 3'd1, 3'd1, 3'd1); rdy = 4'b0001; emp = 4'b0001;
      step("R4");

      // R5: accept rotates 0,1,2 in turn
      rdy = '1; emp = '0; acc = 1'b1;
      step("R5"); step("R5"); step("R5");
      acc = 1'b0;
      step("R5"); step("R5");

      // R9: repeated samples within one cycle
      @(negedge clk); model(ev, et);
      check("R9", sel_valid, int'(sel_tid), ev, et);
      #1 check("R9", sel_valid, int'(sel_tid), ev, et);
      rdy = 4'b0100; #1 model(ev, et);
      check("R9", sel_valid, int'(sel_tid), ev, et);
      @(posedge clk); #1;

      // R6: accept under age policies leaves list alone; then probe in rotating mode
      rdy = '1; seq = {16'd5, 16'd5, 16'd9, 16'd7}; acc = 1'b1;
      policy = 2'd1; step("R7");
      policy = 2'd2; step("R2");
      policy = 2'd3; step("R2");
      acc = 1'b0; policy = 2'd0; step("R6");

      // R7: tie to lower index, empty excluded
      policy = 2'd1; emp = 4'b0100; seq = {16'd3, 16'd3, 16'd8, 16'd8};
      step("R7");
      set_all(3'd2, 3'd4, 3'd0, 3'd0); step("R7");

      // R10: single-thread variant
      for (int c = 0; c < 8; c++) begin
         st1 = 3'(c); rdy1 = c[0]; emp1 = c[1];
         @(negedge clk);
         check("R10", v1, int'(tid1), ok_status(3'(c)), 0);
         @(posedge clk); #1;
      end

      // random traffic compared against the model every cycle
      for (int n = 0; n < 3000; n++) begin
         policy = 2'($urandom_range(0, 3));
         for (int t = 0; t < NT; t++) begin
            status[t*3 +: 3] = ($urandom_range(0, 3) != 0) ? 3'($urandom_range(0, 1)) : 3'($urandom_range(0, 7));
            seq[t*SW +: SW]  = SW'($urandom_range(0, 6));
         end
         rdy = 4'($urandom); emp = 4'($urandom) & 4'($urandom);
         acc = 1'($urandom);
         step(policy == 2'd0 ? "R4" : "R7");
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule